// File: doc/BRIEF.md
# Wait-State Memory Strobe Sequencer

This block runs the pins of an external memory port. It takes one request at a time and turns it into a read or write cycle on a 14-bit address bus and a 24-bit data bus. The cycle uses active-low read and write strobes and five active-low space selects. The block is clocked four times faster than the processor, so each clock tick is one quarter of a processor cycle. Four ticks form one processor cycle. Phase 0 is the tick that follows the processor's rising edge.

A requester raises `req` with a direction, a space code, an address, write data and a 3-bit wait count. The block drives the address and the select for one tick. It then pulls the strobe low for two ticks plus four ticks per wait state. After the strobe rises, it keeps the address, the select and any write data for one more tick, and it pulses `ack` in that same tick. Read data is sampled at the edge where the read strobe rises. A new request may be accepted during that final tick, which gives back-to-back cycles with the minimum strobe-high gap.

The data bus comes out as three separate signals: an output value, an output enable and an input value. A pad ring outside this block merges them into one bus.

Top module: `mem_strobe_seq`

## Requirements
- R1: When `rst_n` is low at a clock edge, the block enters its idle state. All selects, `mem_rd_n` and `mem_wr_n` are high, and `mem_d_oe`, `ack` and `rdata` are 0. The quarter-phase counter is set to 0. After reset is released, `pclk_out` follows the pattern 1,1,0,0 over phases 0 to 3.
- R2: A request is taken only at the clock edge that ends phase 3, and only when the block is idle or in the last tick of an access. The access begins in phase 0 with the address and select driven and both strobes still high.
- R3: The space code selects one active-low line: 0 gives bit 0, 1 gives bit 1, 2 gives bit 2, 3 gives bit 3 and 4 gives bit 4 of `mem_sel_n`. At most one select is low at any time. A request with code 5, 6 or 7 is dropped: no select, strobe or `ack` follows it.
- R4: The strobe (`mem_rd_n` for a read, `mem_wr_n` for a write) falls one tick after the address and select become valid, which is in phase 1. It stays low for 2 + 4*w ticks. The wait count w is taken when the request is accepted, so later changes to `req_wait` have no effect.
- R5: `mem_addr` and the select hold the accepted values from the setup tick until one tick after the strobe rises. Changes on the request inputs during that time have no effect. If no new access follows, every select returns high.
- R6: On a write, `mem_d_oe` is high and `mem_d_out` equals the accepted data from the tick the strobe falls until one tick after it rises. `mem_d_oe` is low during reads. It is low at least one tick before the next strobe falls.
- R7: On a read, `rdata` takes the value of `mem_d_in` at the clock edge where `mem_rd_n` rises. It keeps that value until the next read completes.
- R8: `ack` is high for exactly one tick, the tick right after the strobe rises.
- R9: Between two accesses the strobes stay high for at least two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the processor rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 3 | Space code, 0 to 4 valid |
| req_addr | input | 14 | Access address |
| req_wdata | input | 24 | Write data |
| req_wait | input | 3 | Wait-state count |
| ack | output | 1 | One-tick pulse when the access ends |
| rdata | output | 24 | Last captured read data |
| pclk_out | output | 1 | Processor-rate clock, high in phases 0 and 1 |
| mem_addr | output | 14 | Memory address |
| mem_sel_n | output | 5 | Active-low space selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_d_out | output | 24 | Data driven to memory |
| mem_d_oe | output | 1 | Enable for the data output |
| mem_d_in | input | 24 | Data returned by memory |

## Verification
Let k count ticks from the edge that accepts a request, with the setup tick as k = 0. The results are due as follows:
- The strobe is low from k = 1 through k = 2 + 4w.
- `ack` and the captured `rdata` appear at k = 3 + 4w.
- Every select is high again at k = 4 + 4w.

The bench drives each request in a phase 3 tick, which it finds from two low samples of `pclk_out` in a row. It compares all outputs on the falling edge of every tick against these expected values. The returned read data is valid only in the last strobe tick, and the request inputs are scrambled right after acceptance. This shows that the capture edge and the latched fields are the ones the requirements name.

// File: rtl/mss_pkg.sv
// Shared types for the memory strobe sequencer.
// Assumes: none; the package only declares types.
package mss_pkg;
    // Access sequencer states, one per quarter-cycle segment
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/mss_phase_gen.sv
// Quarter-phase counter. It divides the fast clock into processor cycles.
// Assumes: PHASES is a power of two, at least 2. Phase 0 follows the
// processor's rising edge.
module mss_phase_gen #(
    parameter int PHASES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [$clog2(PHASES)-1:0] phase,
    output logic                      last_phase,
    output logic                      pclk
);
    localparam int PH_W = $clog2(PHASES);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(PHASES / 2);

    // Advance the phase each tick and wrap after the last phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign last_phase = (phase == PH_LAST);
    assign pclk       = (phase < PH_HALF);
endmodule

// File: rtl/mss_space_decode.sv
// Turns the request space code into an active-high one-hot select.
// Assumes: NUM_SEL <= 2**SPACE_W. Codes at or above NUM_SEL select nothing.
module mss_space_decode #(
    parameter int SPACE_W = 3,
    parameter int NUM_SEL = 5
) (
    input  logic [SPACE_W-1:0] space,
    output logic [NUM_SEL-1:0] onehot,
    output logic               valid
);
    // One comparator per select line
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign onehot[i] = (space == SPACE_W'(i));
    end

    assign valid = |onehot;
endmodule

// File: rtl/mss_cycle_fsm.sv
// Access sequencer. It holds the request fields, steps through the
// setup/strobe/hold segments, counts strobe ticks, captures read data and
// drives the memory pins from its registered state.
// Assumes: last_phase is high once every PHASES ticks. A setup tick starts
// in phase 0, so the hold tick always falls in the last phase.
module mss_cycle_fsm
    import mss_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 24,
    parameter int WAIT_W  = 3,
    parameter int NUM_SEL = 5,
    parameter int PHASES  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               last_phase,
    input  logic               req,
    input  logic               req_write,
    input  logic [NUM_SEL-1:0] req_sel,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [WAIT_W-1:0]  req_wait,
    input  logic [DATA_W-1:0]  mem_d_in,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [NUM_SEL-1:0] mem_sel_n,
    output logic               mem_rd_n,
    output logic               mem_wr_n,
    output logic [DATA_W-1:0]  mem_d_out,
    output logic               mem_d_oe,
    output logic               ack,
    output logic [DATA_W-1:0]  rdata
);
    localparam int CNT_MAX = PHASES / 2 - 1 + PHASES * ((1 << WAIT_W) - 1);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_t         state;
    logic [CNT_W-1:0]   cnt;
    logic               is_wr;
    logic [NUM_SEL-1:0] sel_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               start;
    logic               strobe_end;

    assign start = req && req_valid && last_phase &&
                   ((state == ST_IDLE) || (state == ST_HOLD));
    assign strobe_end = (state == ST_STROBE) && (cnt == '0);

    // Step through the segments and count down the strobe width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE:   if (start) state <= ST_SETUP;
                ST_SETUP:  state <= ST_STROBE;
                ST_STROBE: if (cnt == '0) state <= ST_HOLD;
                           else cnt <= cnt - 1'b1;
                ST_HOLD:   state <= start ? ST_SETUP : ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
            if (start)
                cnt <= CNT_W'(PHASES / 2 - 1) + CNT_W'(PHASES) * CNT_W'(req_wait);
        end
    end

    // Take the request fields when an access is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr   <= 1'b0;
            sel_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            is_wr   <= req_write;
            sel_q   <= req_sel;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample read data at the edge where the read strobe rises
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (strobe_end && !is_wr)
            rdata_q <= mem_d_in;
    end

    // Decode the pins from the registered state
    always_comb begin
        mem_sel_n = (state == ST_IDLE) ? '1 : ~sel_q;
        mem_rd_n  = !((state == ST_STROBE) && !is_wr);
        mem_wr_n  = !((state == ST_STROBE) && is_wr);
        mem_d_oe  = is_wr && ((state == ST_STROBE) || (state == ST_HOLD));
        mem_d_out = wdata_q;
        mem_addr  = addr_q;
        ack       = (state == ST_HOLD);
        rdata     = rdata_q;
    end

    AST_HOLD_IN_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> last_phase); // R2
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_d_oe |-> mem_rd_n); // R6
endmodule

// File: rtl/mem_strobe_seq.sv
// Top of the wait-state memory strobe sequencer. It connects the phase
// counter, the space decoder and the access sequencer, and checks how their
// outputs line up in time.
// Assumes: clk runs at PHASES times the processor rate. The requester holds
// req until it sees ack, or drops it to cancel before acceptance.
module mem_strobe_seq #(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 24,
    parameter int WAIT_W  = 3,
    parameter int SPACE_W = 3,
    parameter int NUM_SEL = 5,
    parameter int PHASES  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_write,
    input  logic [SPACE_W-1:0] req_space,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [WAIT_W-1:0]  req_wait,
    output logic               ack,
    output logic [DATA_W-1:0]  rdata,
    output logic               pclk_out,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [NUM_SEL-1:0] mem_sel_n,
    output logic               mem_rd_n,
    output logic               mem_wr_n,
    output logic [DATA_W-1:0]  mem_d_out,
    output logic               mem_d_oe,
    input  logic [DATA_W-1:0]  mem_d_in
);
    localparam int PH_W = $clog2(PHASES);

    logic [PH_W-1:0]    phase;
    logic               last_phase;
    logic [NUM_SEL-1:0] sel_onehot;
    logic               space_ok;

    mss_phase_gen #(.PHASES(PHASES)) i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .last_phase (last_phase),
        .pclk       (pclk_out)
    );

    mss_space_decode #(.SPACE_W(SPACE_W), .NUM_SEL(NUM_SEL)) i_decode (
        .space  (req_space),
        .onehot (sel_onehot),
        .valid  (space_ok)
    );

    mss_cycle_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .WAIT_W  (WAIT_W),
        .NUM_SEL (NUM_SEL),
        .PHASES  (PHASES)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_phase (last_phase),
        .req        (req),
        .req_write  (req_write),
        .req_sel    (sel_onehot),
        .req_valid  (space_ok),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_wait   (req_wait),
        .mem_d_in   (mem_d_in),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .mem_d_out  (mem_d_out),
        .mem_d_oe   (mem_d_oe),
        .ack        (ack),
        .rdata      (rdata)
    );

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_sel_n) <= 1); // R3
    AST_FALL_IN_PHASE1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_rd_n) || $fell(mem_wr_n)) |-> (phase == PH_W'(1))); // R4
    AST_STROBE_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> (mem_sel_n != '1)); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_rd_n || !mem_wr_n) && $past(!mem_rd_n || !mem_wr_n)) |-> $stable(mem_addr)); // R5
    AST_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd_n) || $rose(mem_wr_n)) |=> (mem_rd_n && mem_wr_n)); // R9
endmodule

// File: tb/test_mem_strobe_seq.sv
// Self-checking bench: a table of accesses, then directed tests for reset,
// dropped space codes and back-to-back cycles.
module test_mem_strobe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_space = '0;
    logic [13:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic [2:0]  req_wait = '0;
    logic        ack;
    logic [23:0] rdata;
    logic        pclk_out;
    logic [13:0] mem_addr;
    logic [4:0]  mem_sel_n;
    logic        mem_rd_n, mem_wr_n;
    logic [23:0] mem_d_out;
    logic        mem_d_oe;
    logic [23:0] mem_d_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] exp_rdata = '0;
    logic [13:0] last_addr = '0;
    // fields of the access chained after the current one
    logic        nx_wr;
    logic [2:0]  nx_sp, nx_w;
    logic [13:0] nx_ad;
    logic [23:0] nx_wd;

    always #4 clk = ~clk;

    mem_strobe_seq i_mem_strobe_seq (.*);

    // {write, space, addr, wdata, wait, read data}
    localparam int NV = 6;
    localparam logic [68:0] VEC [NV] = '{
        {1'b0, 3'd0, 14'h0123, 24'h000000, 3'd0, 24'hA5C301},
        {1'b1, 3'd1, 14'h1ABC, 24'h5A5A5A, 3'd1, 24'h000000},
        {1'b0, 3'd2, 14'h3FFF, 24'h000000, 3'd2, 24'h13579B},
        {1'b1, 3'd3, 14'h0000, 24'hFFFFFF, 3'd0, 24'h000000},
        {1'b0, 3'd4, 14'h2468, 24'h000000, 3'd3, 24'hFEDCBA},
        {1'b1, 3'd0, 14'h0F0F, 24'h800001, 3'd7, 24'h000000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // pin vector {sel_n, rd_n, wr_n, oe, ack, addr}
    function automatic logic [31:0] pins();
        return {9'd0, mem_sel_n, mem_rd_n, mem_wr_n, mem_d_oe, ack, mem_addr};
    endfunction

    // return at the falling edge inside a phase 3 tick
    task automatic wait_ph3();
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!pclk_out && !prev) break;
            prev = pclk_out;
        end
    endtask

    task automatic run_access(input logic wr, input logic [2:0] sp, input logic [13:0] ad,
                              input logic [23:0] wd, input logic [2:0] w, input logic [23:0] rd,
                              input bit chained, input bit keep);
        int L = 2 + 4 * int'(w);
        if (!chained) begin
            wait_ph3();
            req = 1'b1; req_write = wr; req_space = sp; req_addr = ad;
            req_wdata = wd; req_wait = w;
        end
        mem_d_in = 24'h0BAD01;
        @(posedge clk);
        last_addr = ad;
        for (int k = 0; k <= L + 2; k++) begin
            logic [4:0] esel;
            logic       strb;
            if (keep && k == L + 2) break;
            @(negedge clk);
            strb = (k >= 1) && (k <= L);
            esel = (k <= L + 1) ? ~(5'b1 << sp) : 5'h1F;
            if (k == 0) begin
                // R4 R5: scrambled inputs after acceptance must not matter
                req = 1'b0; req_addr = ~ad; req_wait = ~w; req_wdata = ~wd;
                req_space = sp ^ 3'd1;
                check(chained ? "R9 R2 R3" : "R2 R3", pins(),
                      {9'd0, esel, 1'b1, 1'b1, 1'b0, 1'b0, ad});
            end else if (strb) begin
                check("R4", pins(), {9'd0, esel, !(!wr), !wr ? 1'b1 : 1'b0, wr, 1'b0, ad} ^
                      {14'd0, 1'b0, 1'b1, 1'b1, 16'd0} ^ {14'd0, 1'b0, 1'b1, 1'b1, 16'd0});
                if (wr && k == 1) check("R6", mem_d_out, wd);
                if (k == L) mem_d_in = rd;
            end else if (k == L + 1) begin
                check("R8", pins(), {9'd0, esel, 1'b1, 1'b1, wr, 1'b1, ad});
                if (!wr) exp_rdata = rd;
                check("R7", rdata, exp_rdata);
                if (wr) check("R6", mem_d_out, wd);
                mem_d_in = 24'h0BAD02;
                if (keep) begin
                    req = 1'b1; req_write = nx_wr; req_space = nx_sp; req_addr = nx_ad;
                    req_wdata = nx_wd; req_wait = nx_w;
                end
            end else begin
                check("R5 R6", pins(), {9'd0, 5'h1F, 1'b1, 1'b1, 1'b0, 1'b0, ad});
            end
        end
    endtask

    // watchdog: an expired run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state and the phase pattern after release
        repeat (5) @(negedge clk);
        check("R1", pins(), {9'd0, 5'h1F, 1'b1, 1'b1, 1'b0, 1'b0, 14'd0});
        check("R1", rdata, 24'd0);
        rst_n = 1'b1;
        check("R1", {31'd0, pclk_out}, 32'd1);
        @(negedge clk); check("R1", {31'd0, pclk_out}, 32'd1);
        @(negedge clk); check("R1", {31'd0, pclk_out}, 32'd0);
        @(negedge clk); check("R1", {31'd0, pclk_out}, 32'd0);
        @(negedge clk); check("R1", {31'd0, pclk_out}, 32'd1);

        // table of accesses
        for (int i = 0; i < NV; i++) begin
            logic [68:0] v = VEC[i];
            run_access(v[68], v[67:65], v[64:51], v[50:27], v[26:24], v[23:0], 1'b0, 1'b0);
        end

        // R3: dropped space codes produce no select, strobe or ack
        for (int sp = 5; sp < 8; sp++) begin
            wait_ph3();
            req = 1'b1; req_space = 3'(sp); req_addr = 14'h1111; req_wait = 3'd0;
            @(negedge clk);
            req = 1'b0;
            for (int k = 0; k < 6; k++) begin
                check("R3", pins(), {9'd0, 5'h1F, 1'b1, 1'b1, 1'b0, 1'b0, last_addr});
                @(negedge clk);
            end
        end

        // R9: back-to-back read then write, request held through the hold tick
        nx_wr = 1'b1; nx_sp = 3'd4; nx_ad = 14'h0ACE; nx_wd = 24'hC0FFEE; nx_w = 3'd0;
        run_access(1'b0, 3'd1, 14'h2222, 24'h0, 3'd0, 24'h424242, 1'b0, 1'b1);
        run_access(nx_wr, nx_sp, nx_ad, nx_wd, nx_w, 24'h0, 1'b1, 1'b0);

        // R7: rdata held across a write
        check("R7", rdata, 24'h424242);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule